// File: doc/BRIEF.md
# Floating-Point Operand Classifier and Aligner

This block is the combinational front stage of a single-precision (IEEE 754 binary32) adder/subtractor. It takes two 32-bit operands and an add/subtract control bit. It splits each operand into sign, biased exponent and stored fraction, and sorts each one into one of five classes: zero, subnormal, normal, infinity or NaN. It restores the hidden leading bit. It then right-shifts the mantissa of the operand with the smaller exponent so that both mantissas share one exponent.

Operand pairs that contain a zero, an infinity or a NaN are resolved here. A flag marks each such result, and the final word is supplied as a bypass value, so that these pairs skip the arithmetic path. All other pairs are finite and non-zero, whether normal, subnormal or mixed. For them the block outputs the common exponent, two 27-bit aligned mantissas that carry guard, round and sticky bits, and the two effective signs. The sign of the second operand already includes the subtract control. The downstream adder, normaliser and rounder use these values.

Top module: `fpa_operand_prep`

## Requirements
- R1: The first operand's sign output is bit 31 of the first operand. The second operand's sign output is bit 31 of the second operand XOR the subtract control (1 = subtract).
- R2: Each aligned mantissa is 27 bits. Bit 26 is the hidden bit: 1 when the exponent field (bits 30..23) is non-zero and 0 when it is zero. Bits 25..3 are the stored fraction (bits 22..0). Bits 2..0 are the guard, round and sticky positions, and they are zero before any shift.
- R3: A zero exponent field counts as an effective exponent of 1. The common exponent output is the larger of the two effective exponents.
- R4: The mantissa of the operand with the larger effective exponent is passed on unshifted. The other mantissa is shifted right by the difference of the two effective exponents. When the two are equal, neither is shifted.
- R5: Bits shifted past bit 0 are OR-reduced into the sticky bit (bit 0). A shift of 27 or more places leaves all bits zero except the sticky bit, which is 1 for any non-zero mantissa.
- R6: If either operand is a NaN (exponent all ones, fraction non-zero), the special flag is 1 and the bypass value is 0x7FC00000.
- R7: When both operands are infinities and their effective signs differ, the special flag is 1 and the bypass value is 0x7FC00000.
- R8: When one operand is an infinity and the other is finite, or when both are infinities with equal effective signs, the bypass value is that infinity carrying its effective sign.
- R9: When exactly one operand is zero and the other is finite and non-zero, the bypass value is the non-zero operand carrying its effective sign.
- R10: When both operands are zero, the bypass value is a zero. It is negative only when both effective signs are 1.
- R11: For any pair of finite non-zero operands (normal, subnormal or mixed), the special flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand, binary32 |
| op_b | input | 32 | Second operand, binary32 |
| sub_i | input | 1 | 1 = subtract the second operand, 0 = add |
| sign_a_o | output | 1 | Sign of the first operand |
| sign_b_o | output | 1 | Effective sign of the second operand |
| exp_o | output | 8 | Common (larger effective) exponent |
| man_a_o | output | 27 | Aligned mantissa of the first operand with G/R/S |
| man_b_o | output | 27 | Aligned mantissa of the second operand with G/R/S |
| special_o | output | 1 | Result is resolved here and bypasses arithmetic |
| special_val_o | output | 32 | Bypass result word |

## Verification
Assertions are evaluated on every input combination. They check that the hidden bit follows the exponent field, that the common exponent is never below either effective exponent, and that one mantissa always leaves unshifted. They also check that a non-zero mantissa never disappears in the shifter, that any NaN gives the quiet NaN word, that clashing infinities give NaN, and that finite non-zero pairs never raise the special flag. Only the bench's scenarios can show the exact shifted patterns. These are guard-only at a shift of 24, sticky-only at 27 and beyond, and the mixed and subnormal alignments. The scenarios also pin down the exact bypass words, the precedence of NaN over infinity over zero, and the signs of zero sums under subtraction.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int GRS_W  = 3;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_NAN  = 3'd4
  } fp_class_e;

endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack
  import fpa_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W,
  localparam int WW = 1 + EW + FW,
  localparam int MW = FW + 1
) (
  input  logic [WW-1:0] word_i,
  output logic          sign_o,
  output logic [EW-1:0] exp_eff_o,
  output logic [MW-1:0] mant_o,
  output fp_class_e     cls_o
);

  logic [EW-1:0] exp_f;
  logic [FW-1:0] frac_f;
  logic          exp_zero;
  logic          exp_ones;
  logic          frac_zero;

  always_comb begin
    sign_o    = word_i[WW-1];
    exp_f     = word_i[WW-2 -: EW];
    frac_f    = word_i[FW-1:0];
    exp_zero  = (exp_f == '0);
    exp_ones  = (exp_f == '1);
    frac_zero = (frac_f == '0);
    exp_eff_o = exp_zero ? EW'(1) : exp_f;
    mant_o    = {~exp_zero, frac_f};
    if (exp_zero)      cls_o = frac_zero ? CLS_ZERO : CLS_SUB;
    else if (exp_ones) cls_o = frac_zero ? CLS_INF  : CLS_NAN;
    else               cls_o = CLS_NORM;
  end

  // R2: hidden bit agrees with the class decision
  always_comb begin
    if (cls_o == CLS_SUB || cls_o == CLS_ZERO)
      a_r2_hidden_low: assert (!mant_o[MW-1]);
    if (cls_o == CLS_NORM)
      a_r2_hidden_high: assert (mant_o[MW-1]);
  end

endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
  parameter int AW = 27,
  parameter int EW = 8,
  localparam int SW = $clog2(AW + 1)
) (
  input  logic [AW-1:0] mant_i,
  input  logic [EW-1:0] shamt_i,
  output logic [AW-1:0] mant_o
);

  logic [SW-1:0]   sh_cap;
  logic [2*AW-1:0] stg [0:SW];
  logic            sticky;

  always_comb begin
    if (int'(shamt_i) >= AW) sh_cap = SW'(AW);
    else                     sh_cap = SW'(shamt_i);
  end

  assign stg[0] = {mant_i, {AW{1'b0}}};

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = sh_cap[k] ? (stg[k] >> STEP) : stg[k];
  end

  always_comb begin
    sticky = |stg[SW][AW-1:0];
    mant_o = {stg[SW][2*AW-1:AW+1], stg[SW][AW] | sticky};
  end

  // R5: a non-zero mantissa never vanishes through the shifter
  always_comb begin
    if (mant_i != '0)
      a_r5_sticky_kept: assert (mant_o != '0);
    if (shamt_i == '0)
      a_r4_zero_shift_identity: assert (mant_o == mant_i);
  end

endmodule

// File: rtl/fpa_special.sv
module fpa_special
  import fpa_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W,
  localparam int WW = 1 + EW + FW
) (
  input  fp_class_e     cls_a_i,
  input  fp_class_e     cls_b_i,
  input  logic [WW-1:0] word_a_i,
  input  logic [WW-1:0] word_b_i,
  output logic          special_o,
  output logic [WW-1:0] value_o
);

  localparam logic [WW-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  logic any_nan, a_inf, b_inf, a_zero, b_zero;

  always_comb begin
    any_nan   = (cls_a_i == CLS_NAN) || (cls_b_i == CLS_NAN);
    a_inf     = (cls_a_i == CLS_INF);
    b_inf     = (cls_b_i == CLS_INF);
    a_zero    = (cls_a_i == CLS_ZERO);
    b_zero    = (cls_b_i == CLS_ZERO);
    special_o = 1'b1;
    value_o   = QNAN;
    if (any_nan) begin
      value_o = QNAN;
    end else if (a_inf && b_inf) begin
      value_o = (word_a_i[WW-1] == word_b_i[WW-1]) ? word_a_i : QNAN;
    end else if (a_inf) begin
      value_o = word_a_i;
    end else if (b_inf) begin
      value_o = word_b_i;
    end else if (a_zero && b_zero) begin
      value_o = {word_a_i[WW-1] & word_b_i[WW-1], {(WW-1){1'b0}}};
    end else if (a_zero) begin
      value_o = word_b_i;
    end else if (b_zero) begin
      value_o = word_a_i;
    end else begin
      special_o = 1'b0;
    end
  end

  // R6, R7, R11
  always_comb begin
    if (any_nan)
      a_r6_nan_quiet: assert (special_o && value_o == QNAN);
    if (a_inf && b_inf && (word_a_i[WW-1] != word_b_i[WW-1]))
      a_r7_inf_clash: assert (special_o && value_o == QNAN);
    if ((cls_a_i == CLS_NORM || cls_a_i == CLS_SUB) &&
        (cls_b_i == CLS_NORM || cls_b_i == CLS_SUB))
      a_r11_finite_not_special: assert (!special_o);
  end

endmodule

// File: rtl/fpa_operand_prep.sv
module fpa_operand_prep
  import fpa_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W,
  parameter int GW = GRS_W,
  localparam int WW = 1 + EW + FW,
  localparam int MW = FW + 1,
  localparam int AW = MW + GW
) (
  input  logic [WW-1:0] op_a,
  input  logic [WW-1:0] op_b,
  input  logic          sub_i,
  output logic          sign_a_o,
  output logic          sign_b_o,
  output logic [EW-1:0] exp_o,
  output logic [AW-1:0] man_a_o,
  output logic [AW-1:0] man_b_o,
  output logic          special_o,
  output logic [WW-1:0] special_val_o
);

  logic [WW-1:0] word   [0:1];
  logic          sgn    [0:1];
  logic [EW-1:0] e_eff  [0:1];
  logic [MW-1:0] mant   [0:1];
  fp_class_e     cls    [0:1];
  logic [AW-1:0] ext    [0:1];

  logic          a_ge;
  logic [EW-1:0] shamt;
  logic [AW-1:0] small_m;
  logic [AW-1:0] aligned;

  assign word[0] = op_a;
  assign word[1] = {op_b[WW-1] ^ sub_i, op_b[WW-2:0]};

  for (genvar i = 0; i < 2; i++) begin : g_op
    fpa_unpack #(.EW(EW), .FW(FW)) i_unpack (
      .word_i    (word[i]),
      .sign_o    (sgn[i]),
      .exp_eff_o (e_eff[i]),
      .mant_o    (mant[i]),
      .cls_o     (cls[i])
    );
    assign ext[i] = {mant[i], {GW{1'b0}}};
  end

  always_comb begin
    a_ge    = (e_eff[0] >= e_eff[1]);
    exp_o   = a_ge ? e_eff[0] : e_eff[1];
    shamt   = a_ge ? (e_eff[0] - e_eff[1]) : (e_eff[1] - e_eff[0]);
    small_m = a_ge ? ext[1] : ext[0];
  end

  fpa_align #(.AW(AW), .EW(EW)) i_align (
    .mant_i  (small_m),
    .shamt_i (shamt),
    .mant_o  (aligned)
  );

  always_comb begin
    man_a_o  = a_ge ? ext[0]  : aligned;
    man_b_o  = a_ge ? aligned : ext[1];
    sign_a_o = sgn[0];
    sign_b_o = sgn[1];
  end

  fpa_special #(.EW(EW), .FW(FW)) i_special (
    .cls_a_i   (cls[0]),
    .cls_b_i   (cls[1]),
    .word_a_i  (word[0]),
    .word_b_i  (word[1]),
    .special_o (special_o),
    .value_o   (special_val_o)
  );

  // R3, R4
  always_comb begin
    a_r3_exp_is_max: assert (exp_o >= e_eff[0] && exp_o >= e_eff[1]);
    a_r4_leader_unshifted: assert (man_a_o == ext[0] || man_b_o == ext[1]);
  end

endmodule

// File: tb/test_fpa_operand_prep.sv
module test_fpa_operand_prep;

  logic        clk;
  logic [31:0] op_a, op_b;
  logic        sub_i;
  logic        sign_a_o, sign_b_o, special_o;
  logic [7:0]  exp_o;
  logic [26:0] man_a_o, man_b_o;
  logic [31:0] special_val_o;

  fpa_operand_prep i_fpa_operand_prep (
    .op_a(op_a), .op_b(op_b), .sub_i(sub_i),
    .sign_a_o(sign_a_o), .sign_b_o(sign_b_o), .exp_o(exp_o),
    .man_a_o(man_a_o), .man_b_o(man_b_o),
    .special_o(special_o), .special_val_o(special_val_o)
  );

  typedef struct {
    logic        spc;
    logic [31:0] val;
    logic [7:0]  ex;
    logic [26:0] ma, mb;
    logic        sa, sb;
    string       tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic drive_spc(input logic [31:0] a, b, input logic s,
                           input logic [31:0] v, input string tag);
    item_t it;
    @(negedge clk);
    op_a = a; op_b = b; sub_i = s;
    it.spc = 1'b1; it.val = v; it.ex = '0; it.ma = '0; it.mb = '0;
    it.sa = 1'b0; it.sb = 1'b0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drive_ar(input logic [31:0] a, b, input logic s,
                          input logic [7:0] ex, input logic [26:0] ma, mb,
                          input logic sa, sb, input string tag);
    item_t it;
    @(negedge clk);
    op_a = a; op_b = b; sub_i = s;
    it.spc = 1'b0; it.val = '0; it.ex = ex; it.ma = ma; it.mb = mb;
    it.sa = sa; it.sb = sb; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_cmp++;
        if (it.spc) begin
          if (!special_o || special_val_o !== it.val) begin
            n_bad++;
            $display("FAIL %s: spc=%0b val=%08h expected spc=1 val=%08h",
                     it.tag, special_o, special_val_o, it.val);
          end
        end else begin
          if (special_o || exp_o !== it.ex || man_a_o !== it.ma ||
              man_b_o !== it.mb || sign_a_o !== it.sa || sign_b_o !== it.sb) begin
            n_bad++;
            $display("FAIL %s: spc=%0b exp=%02h ma=%07h mb=%07h sa=%0b sb=%0b expected spc=0 exp=%02h ma=%07h mb=%07h sa=%0b sb=%0b",
                     it.tag, special_o, exp_o, man_a_o, man_b_o, sign_a_o, sign_b_o,
                     it.ex, it.ma, it.mb, it.sa, it.sb);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: timeout actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    op_a = '0; op_b = '0; sub_i = 1'b0;
    // initial state, all-zero inputs: R10
    drive_spc(32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, "R10 idle zeros");
    // R2 R3 equal exponents
    drive_ar(32'h3F80_0000, 32'h3F80_0000, 1'b0, 8'h7F, 27'h400_0000, 27'h400_0000, 0, 0, "R2 1+1");
    // R1 subtract flips second sign
    drive_ar(32'h3F80_0000, 32'h3FC0_0000, 1'b1, 8'h7F, 27'h400_0000, 27'h600_0000, 0, 1, "R1 1-1.5");
    drive_ar(32'hBF80_0000, 32'hBFC0_0000, 1'b1, 8'h7F, 27'h400_0000, 27'h600_0000, 1, 0, "R1 -1--1.5");
    // R4 shifts, both orders
    drive_ar(32'h4000_0000, 32'h3F80_0000, 1'b0, 8'h80, 27'h400_0000, 27'h200_0000, 0, 0, "R4 2+1");
    drive_ar(32'h3F80_0000, 32'h4000_0000, 1'b0, 8'h80, 27'h200_0000, 27'h400_0000, 0, 0, "R4 1+2");
    // R5 guard/sticky
    drive_ar(32'h4B00_0000, 32'h3F80_0001, 1'b0, 8'h96, 27'h400_0000, 27'h000_0009, 0, 0, "R5 diff23 sticky");
    drive_ar(32'h4B80_0000, 32'h3F80_0000, 1'b0, 8'h97, 27'h400_0000, 27'h000_0004, 0, 0, "R5 diff24 guard");
    drive_ar(32'h4D00_0000, 32'h3F80_0000, 1'b0, 8'h9A, 27'h400_0000, 27'h000_0001, 0, 0, "R5 diff27");
    drive_ar(32'h3F80_0000, 32'h7E80_0000, 1'b0, 8'hFD, 27'h000_0001, 27'h400_0000, 0, 0, "R5 diff126");
    // R3 R11 mixed and subnormal
    drive_ar(32'h0080_0000, 32'h0040_0000, 1'b0, 8'h01, 27'h400_0000, 27'h200_0000, 0, 0, "R3 mixed diff0");
    drive_ar(32'h0100_0000, 32'h0000_0001, 1'b0, 8'h02, 27'h400_0000, 27'h000_0004, 0, 0, "R11 mixed diff1");
    drive_ar(32'h0000_0003, 32'h8000_0001, 1'b0, 8'h01, 27'h000_0018, 27'h000_0008, 0, 1, "R11 both sub");
    // R6 NaN
    drive_spc(32'h7F80_0001, 32'h3F80_0000, 1'b0, 32'h7FC0_0000, "R6 nan+1");
    drive_spc(32'h7F80_0000, 32'hFFFF_FFFF, 1'b0, 32'h7FC0_0000, "R6 inf+nan");
    drive_spc(32'h0000_0000, 32'hFFC0_0000, 1'b1, 32'h7FC0_0000, "R6 zero-nan");
    // R7 clashing infinities
    drive_spc(32'h7F80_0000, 32'h7F80_0000, 1'b1, 32'h7FC0_0000, "R7 inf-inf");
    drive_spc(32'h7F80_0000, 32'hFF80_0000, 1'b0, 32'h7FC0_0000, "R7 inf+-inf");
    // R8 infinities
    drive_spc(32'hFF80_0000, 32'h3F80_0000, 1'b0, 32'hFF80_0000, "R8 -inf+1");
    drive_spc(32'h3F80_0000, 32'h7F80_0000, 1'b1, 32'hFF80_0000, "R8 1-inf");
    drive_spc(32'h7F80_0000, 32'h7F80_0000, 1'b0, 32'h7F80_0000, "R8 inf+inf");
    drive_spc(32'h0000_0000, 32'hFF80_0000, 1'b0, 32'hFF80_0000, "R8 0+-inf");
    // R9 zero passes other operand
    drive_spc(32'h0000_0000, 32'hC040_0000, 1'b0, 32'hC040_0000, "R9 0+x");
    drive_spc(32'h8000_0000, 32'h0000_0001, 1'b1, 32'h8000_0001, "R9 -0-sub");
    drive_spc(32'h4049_0FDB, 32'h8000_0000, 1'b0, 32'h4049_0FDB, "R9 x+-0");
    // R10 zero signs
    drive_spc(32'h8000_0000, 32'h8000_0000, 1'b0, 32'h8000_0000, "R10 -0+-0");
    drive_spc(32'h8000_0000, 32'h0000_0000, 1'b1, 32'h8000_0000, "R10 -0-0");
    drive_spc(32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0000, "R10 0-0");
    drive_spc(32'h8000_0000, 32'h8000_0000, 1'b1, 32'h0000_0000, "R10 -0--0");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule